// File: doc/BRIEF.md
# Message Match List Engine

This block decides where an incoming message goes before any payload moves. The caller presents a header made of three fields: the sender's group id, the sender's rank inside that group, and a 64-bit match key. The engine compares the header against an ordered list of up to `N_ENTRIES` match entries. Each entry holds expected values for the three fields, a don't-care flag for the group, a don't-care flag for the rank and a per-bit ignore mask for the key. The first valid entry whose cared-for fields all agree wins, and the engine reports that entry's index and target region.

When no entry agrees, the message is either discarded or steered to an overflow region, where it can be matched again later. A configuration input selects which. The engine examines one entry per clock, so a header is resolved in at most `N_ENTRIES` cycles. It takes no new header until the current one is resolved. Software loads entries through a single-entry write port. A write that arrives during a search is dropped, so the list cannot change under a search.

Top module: `mle_match_engine`

## Requirements
- R1: After reset `hdr_ready` is 1, `res_valid` is 0 and every entry is invalid, so the first header resolves as a miss.
- R2: An entry matches only if the group id, the rank and the key all agree, except where a field is marked don't-care. A difference in any single cared-for field gives no match.
- R3: `wr_gid_any`=1 makes the group id don't-care and `wr_rank_any`=1 makes the rank don't-care. A 1 in bit i of `wr_key_ign` excludes key bit i from the comparison.
- R4: When several entries match, the one with the lowest index is reported.
- R5: A hit gives a one-cycle `res_valid` with `res_hit`=1, `res_miss`=0, `res_to_ovf`=0, `res_idx` = the entry index and `res_tgt` = that entry's target.
- R6: A miss with `cfg_miss_to_ovf`=0 gives `res_hit`=0, `res_miss`=1 and `res_to_ovf`=0, which means the message is discarded.
- R7: A miss with `cfg_miss_to_ovf`=1 gives `res_miss`=1 and `res_to_ovf`=1. The policy is sampled in the cycle the header is accepted.
- R8: A header is accepted on a rising edge with `hdr_valid` and `hdr_ready` both high. A hit on entry k raises `res_valid` k+1 cycles later. A miss raises it `N_ENTRIES` cycles later.
- R9: `hdr_ready` is 0 from the accepting edge until the cycle of the result. Each accepted header produces exactly one `res_valid` pulse, one cycle long.
- R10: A write (`wr_en`=1) while a search is in progress is ignored. A write while idle takes effect for the next header.
- R11: An entry written with `wr_vld`=0 never matches, whatever its fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_miss_to_ovf | input | 1 | Miss policy: 1 steers to overflow, 0 discards |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vld | input | 1 | Valid flag for the written entry |
| wr_gid | input | 16 | Expected group id |
| wr_gid_any | input | 1 | Group id is don't-care |
| wr_rank | input | 16 | Expected rank |
| wr_rank_any | input | 1 | Rank is don't-care |
| wr_key | input | 64 | Expected match key |
| wr_key_ign | input | 64 | Per-bit key ignore mask |
| wr_tgt | input | 8 | Target region id of the entry |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Engine idle and able to accept a header |
| hdr_gid | input | 16 | Header group id |
| hdr_rank | input | 16 | Header rank |
| hdr_key | input | 64 | Header match key |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | An entry matched |
| res_miss | output | 1 | No entry matched |
| res_to_ovf | output | 1 | Miss is sent to overflow (0 with a miss: discarded) |
| res_idx | output | IDX_W | Index of the matching entry |
| res_tgt | output | 8 | Target region of the matching entry |

## Verification
The bench fills the list with overlapping entries and checks that the lowest matching index wins. A design that kept scanning or prioritized the highest index would report a later entry. Headers that differ from an entry in only one cared-for field must miss. Headers that differ only in ignored key bits or don't-care fields must hit. A comparator that mishandles the masks fails one of these two cases.

Latency is checked against the index of the hit, including a hit on the last entry and a full miss. This exposes an off-by-one in the scan counter or a scan that stops early. A write is injected in the middle of a search, and the bench then shows that the list is unchanged. It also checks that invalid entries are skipped and that the miss policy latched at acceptance selects discard or overflow.

// File: rtl/mle_pkg.sv
// Package: shared widths and the stored match entry record.
// Assumes all users take field widths from here so the record layout agrees.
package mle_pkg;
    localparam int GID_W  = 16;
    localparam int RANK_W = 16;
    localparam int KEY_W  = 64;
    localparam int TGT_W  = 8;

    // One match list entry as held in the table.
    typedef struct packed {
        logic              vld;
        logic [GID_W-1:0]  gid;
        logic              gid_any;
        logic [RANK_W-1:0] rank;
        logic              rank_any;
        logic [KEY_W-1:0]  key;
        logic [KEY_W-1:0]  key_ign;
        logic [TGT_W-1:0]  tgt;
    } mle_entry_t;

    // Header fields captured at acceptance.
    typedef struct packed {
        logic [GID_W-1:0]  gid;
        logic [RANK_W-1:0] rank;
        logic [KEY_W-1:0]  key;
    } mle_hdr_t;
endpackage

// File: rtl/mle_entry_table.sv
// Module: entry storage with one write port and one combinational read port.
// Writes are refused while wr_block is high. Reset clears every entry,
// which makes them all invalid. The read index is assumed to stay below N_ENTRIES.
module mle_entry_table
    import mle_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_block,
    input  logic [IDX_W-1:0] wr_idx,
    input  mle_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output mle_entry_t       rd_entry
);
    mle_entry_t [N_ENTRIES-1:0] tbl_q;

    logic wr_go;
    // Purpose: a write is taken only when the search is not running.
    assign wr_go = wr_en && !wr_block;

    for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_slot
        // Purpose: hold one entry, loaded when the write addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_q[gi] <= '0;
            else if (wr_go && (wr_idx == IDX_W'(gi)))
                tbl_q[gi] <= wr_entry;
        end
    end

    // Purpose: present the entry the scan is visiting.
    assign rd_entry = tbl_q[rd_idx];

    // R10: a blocked cycle leaves the whole table unchanged.
    p_table_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |=> $stable(tbl_q));
endmodule

// File: rtl/mle_entry_cmp.sv
// Module: compares one entry against a header, combinationally.
// A field marked don't-care, or an ignored key bit, never blocks a match.
// An invalid entry never matches.
module mle_entry_cmp
    import mle_pkg::*;
(
    input  mle_entry_t entry,
    input  mle_hdr_t   hdr,
    output logic       is_match
);
    logic gid_ok, rank_ok, key_ok;

    // Purpose: evaluate each field under its mask, then combine them.
    always_comb begin
        gid_ok   = entry.gid_any  || (entry.gid == hdr.gid);
        rank_ok  = entry.rank_any || (entry.rank == hdr.rank);
        key_ok   = ((entry.key ^ hdr.key) & ~entry.key_ign) == '0;
        is_match = entry.vld && gid_ok && rank_ok && key_ok;
    end
endmodule

// File: rtl/mle_search_ctl.sv
// Module: scan controller. Accepts a header when idle, then walks the list
// one entry per cycle from index 0. It stops at the first match or after
// the last entry and registers the result as a one-cycle strobe.
// Assumes is_match refers to the entry at scan_idx in the same cycle.
module mle_search_ctl
    import mle_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_miss_to_ovf,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  mle_hdr_t         hdr_in,
    output mle_hdr_t         hdr_q,
    output logic             busy,
    output logic [IDX_W-1:0] scan_idx,
    input  logic             is_match,
    input  logic [TGT_W-1:0] match_tgt,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_to_ovf,
    output logic [IDX_W-1:0] res_idx,
    output logic [TGT_W-1:0] res_tgt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    logic busy_q, pol_q, accept;
    logic [IDX_W-1:0] idx_q;

    // Purpose: the engine takes a header only while no scan is running.
    assign hdr_ready = !busy_q;
    assign accept    = hdr_valid && !busy_q;
    assign busy      = busy_q;
    assign scan_idx  = idx_q;

    // Purpose: sequence the scan and register the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            pol_q      <= 1'b0;
            idx_q      <= '0;
            hdr_q      <= '0;
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_to_ovf <= 1'b0;
            res_idx    <= '0;
            res_tgt    <= '0;
        end else begin
            res_valid <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                hdr_q  <= hdr_in;
                pol_q  <= cfg_miss_to_ovf;
            end else if (busy_q) begin
                if (is_match) begin
                    busy_q     <= 1'b0;
                    res_valid  <= 1'b1;
                    res_hit    <= 1'b1;
                    res_miss   <= 1'b0;
                    res_to_ovf <= 1'b0;
                    res_idx    <= idx_q;
                    res_tgt    <= match_tgt;
                end else if (idx_q == LAST_IDX) begin
                    busy_q     <= 1'b0;
                    res_valid  <= 1'b1;
                    res_hit    <= 1'b0;
                    res_miss   <= 1'b1;
                    res_to_ovf <= pol_q;
                    res_idx    <= '0;
                    res_tgt    <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Checker state: cycles elapsed since the last acceptance.
    logic [IDX_W:0] lat_q;
    // Purpose: count edges since acceptance, independently of the scan index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (accept)
            lat_q <= '0;
        else if (busy_q)
            lat_q <= lat_q + 1'b1;
    end

    // R5: a result is either a hit or a miss, never both or neither.
    p_hit_xor_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit ^ res_miss));
    // R7: the overflow steer only ever accompanies a miss.
    p_ovf_needs_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_to_ovf) |-> res_miss);
    // R8: a hit on entry k arrives k+1 cycles after acceptance.
    p_hit_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (lat_q == ({1'b0, res_idx} + 1'b1)));
    // R8: a miss arrives after the whole list has been scanned.
    p_miss_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (lat_q == (IDX_W+1)'(N_ENTRIES)));
    // R9: the result strobe lasts a single cycle.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9: an accepted header closes the input until its result is out.
    p_closed_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> !hdr_ready);
endmodule

// File: rtl/mle_match_engine.sv
// Module: top of the message match list engine. Joins the entry table,
// the comparator and the scan controller. Assumes the writer keeps wr_idx
// below N_ENTRIES and gives a writer nothing back when a write is refused.
module mle_match_engine
    import mle_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_miss_to_ovf,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_vld,
    input  logic [GID_W-1:0]  wr_gid,
    input  logic              wr_gid_any,
    input  logic [RANK_W-1:0] wr_rank,
    input  logic              wr_rank_any,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [KEY_W-1:0]  wr_key_ign,
    input  logic [TGT_W-1:0]  wr_tgt,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [GID_W-1:0]  hdr_gid,
    input  logic [RANK_W-1:0] hdr_rank,
    input  logic [KEY_W-1:0]  hdr_key,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_to_ovf,
    output logic [IDX_W-1:0]  res_idx,
    output logic [TGT_W-1:0]  res_tgt
);
    mle_entry_t       wr_entry, cur_entry;
    mle_hdr_t         hdr_in, hdr_q;
    logic             busy, is_match;
    logic [IDX_W-1:0] scan_idx;

    // Purpose: pack the write port and the header pins into records.
    always_comb begin
        wr_entry = '{vld: wr_vld, gid: wr_gid, gid_any: wr_gid_any,
                     rank: wr_rank, rank_any: wr_rank_any,
                     key: wr_key, key_ign: wr_key_ign, tgt: wr_tgt};
        hdr_in   = '{gid: hdr_gid, rank: hdr_rank, key: hdr_key};
    end

    mle_entry_table #(.N_ENTRIES(N_ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_block (busy),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (scan_idx),
        .rd_entry (cur_entry)
    );

    mle_entry_cmp u_cmp (
        .entry    (cur_entry),
        .hdr      (hdr_q),
        .is_match (is_match)
    );

    mle_search_ctl #(.N_ENTRIES(N_ENTRIES)) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_miss_to_ovf (cfg_miss_to_ovf),
        .hdr_valid       (hdr_valid),
        .hdr_ready       (hdr_ready),
        .hdr_in          (hdr_in),
        .hdr_q           (hdr_q),
        .busy            (busy),
        .scan_idx        (scan_idx),
        .is_match        (is_match),
        .match_tgt       (cur_entry.tgt),
        .res_valid       (res_valid),
        .res_hit         (res_hit),
        .res_miss        (res_miss),
        .res_to_ovf      (res_to_ovf),
        .res_idx         (res_idx),
        .res_tgt         (res_tgt)
    );

    // R11: a reported hit never names an entry that is invalid now.
    p_hit_entry_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_match) |-> cur_entry.vld);
endmodule

// File: tb/tb_mle_match_engine.sv
// Bench: directed corner cases, then random stimulus with a fixed seed.
// Every result is compared against a reference list model held in the bench.
module tb_mle_match_engine;
    localparam int N = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          cfg_miss_to_ovf = 1'b0;
    logic          wr_en = 1'b0, wr_vld = 1'b0, wr_gid_any = 1'b0, wr_rank_any = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [15:0]   wr_gid = '0, wr_rank = '0;
    logic [63:0]   wr_key = '0, wr_key_ign = '0;
    logic [7:0]    wr_tgt = '0;
    logic          hdr_valid = 1'b0;
    logic          hdr_ready;
    logic [15:0]   hdr_gid = '0, hdr_rank = '0;
    logic [63:0]   hdr_key = '0;
    logic          res_valid, res_hit, res_miss, res_to_ovf;
    logic [IW-1:0] res_idx;
    logic [7:0]    res_tgt;

    mle_match_engine #(.N_ENTRIES(N)) dut (.*);

    // Reference model of the list.
    logic        m_vld [N];
    logic [15:0] m_gid [N];
    logic        m_gany[N];
    logic [15:0] m_rank[N];
    logic        m_rany[N];
    logic [63:0] m_key [N];
    logic [63:0] m_kign[N];
    logic [7:0]  m_tgt [N];

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_find(input logic [15:0] g, input logic [15:0] r,
                                      input logic [63:0] k);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && (m_gany[i] || m_gid[i] == g) && (m_rany[i] || m_rank[i] == r)
                && (((m_key[i] ^ k) & ~m_kign[i]) == 64'd0))
                return i;
        return -1;
    endfunction

    task automatic put_entry(input int i, input bit v, input logic [15:0] g, input bit ga,
                             input logic [15:0] r, input bit ra, input logic [63:0] k,
                             input logic [63:0] ki, input logic [7:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_vld = v; wr_gid = g; wr_gid_any = ga;
        wr_rank = r; wr_rank_any = ra; wr_key = k; wr_key_ign = ki; wr_tgt = t;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_vld[i] = v; m_gid[i] = g; m_gany[i] = ga; m_rank[i] = r; m_rany[i] = ra;
        m_key[i] = k; m_kign[i] = ki; m_tgt[i] = t;
    endtask

    // Send one header and check the result, its latency and the handshake.
    // With inject set, a catch-all write to entry 0 is attempted mid-search.
    task automatic run_hdr(input logic [15:0] g, input logic [15:0] r, input logic [63:0] k,
                           input bit pol, input bit inject, input string req);
        int exp_i, lat;
        bit ready_ok;
        exp_i = model_find(g, r, k);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_gid = g; hdr_rank = r; hdr_key = k; cfg_miss_to_ovf = pol;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0; cfg_miss_to_ovf = ~pol;   // changing it now must not matter (R7)
        lat = 0;
        ready_ok = (hdr_ready == 1'b0);
        if (inject) begin
            wr_en = 1'b1; wr_idx = '0; wr_vld = 1'b1; wr_gid_any = 1'b1; wr_rank_any = 1'b1;
            wr_key_ign = '1; wr_tgt = 8'hEE;
        end
        while (lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            lat++;
            if (res_valid) break;
            if (hdr_ready) ready_ok = 1'b0;
        end
        chk(res_valid == 1'b1, req, "result strobe seen", 64'(res_valid), 64'd1);
        chk(ready_ok, "R9", "hdr_ready low during search", 64'(ready_ok), 64'd1);
        if (exp_i >= 0) begin
            chk(res_hit == 1'b1 && res_miss == 1'b0 && res_to_ovf == 1'b0, "R5",
                {req, " hit flags"}, {61'd0, res_hit, res_miss, res_to_ovf}, 64'd4);
            chk(res_idx == IW'(exp_i), "R4", {req, " hit index"}, 64'(res_idx), 64'(exp_i));
            chk(res_tgt == m_tgt[exp_i], "R5", {req, " target"}, 64'(res_tgt), 64'(m_tgt[exp_i]));
            chk(lat == exp_i + 1, "R8", {req, " hit latency"}, 64'(lat), 64'(exp_i + 1));
        end else begin
            chk(res_hit == 1'b0 && res_miss == 1'b1, pol ? "R7" : "R6", {req, " miss flags"},
                {62'd0, res_hit, res_miss}, 64'd1);
            chk(res_to_ovf == pol, pol ? "R7" : "R6", {req, " miss policy"},
                64'(res_to_ovf), 64'(pol));
            chk(lat == N, "R8", {req, " miss latency"}, 64'(lat), 64'(N));
        end
        @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0 && hdr_ready == 1'b1, "R9", "strobe one cycle, ready again",
            {62'd0, res_valid, hdr_ready}, 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] g, r;
        logic [63:0] k;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_gid[i] = 0; m_gany[i] = 0; m_rank[i] = 0;
            m_rany[i] = 0; m_key[i] = 0; m_kign[i] = 0; m_tgt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports, then an empty list misses.
        chk(hdr_ready == 1'b1, "R1", "hdr_ready after reset", 64'(hdr_ready), 64'd1);
        chk(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 64'd0);
        run_hdr(16'h0, 16'h0, 64'h0, 1'b0, 1'b0, "R1");

        // R11: an invalid entry ahead of a valid twin is skipped.
        put_entry(2, 0, 16'h11, 0, 16'h5, 0, 64'hABCD, 64'h0, 8'h22);
        put_entry(5, 1, 16'h11, 0, 16'h5, 0, 64'hABCD, 64'h0, 8'h55);
        run_hdr(16'h11, 16'h5, 64'hABCD, 1'b0, 1'b0, "R11");
        // R4: two valid matches, the lower index wins.
        put_entry(3, 1, 16'h11, 0, 16'h5, 0, 64'hABCD, 64'h0, 8'h33);
        run_hdr(16'h11, 16'h5, 64'hABCD, 1'b0, 1'b0, "R4");
        // R2: a single differing field gives a miss.
        run_hdr(16'h11, 16'h6, 64'hABCD, 1'b0, 1'b0, "R2");
        run_hdr(16'h12, 16'h5, 64'hABCD, 1'b1, 1'b0, "R2");
        run_hdr(16'h11, 16'h5, 64'hABCC, 1'b0, 1'b0, "R2");
        // R3: don't-care group and rank, ignored low key byte.
        put_entry(8, 1, 16'h0, 1, 16'h0, 1, 64'hFEED_0000_0000_1200, 64'hFF, 8'h88);
        run_hdr(16'h7777, 16'h3, 64'hFEED_0000_0000_12A5, 1'b0, 1'b0, "R3");
        run_hdr(16'h7777, 16'h3, 64'hFEED_0000_0000_13A5, 1'b1, 1'b0, "R3");
        // R8: hit on the last entry takes the full scan length.
        put_entry(15, 1, 16'h99, 0, 16'h9, 0, 64'h1, 64'h0, 8'hF0);
        run_hdr(16'h99, 16'h9, 64'h1, 1'b0, 1'b0, "R8");
        // R6 / R7: miss under each policy.
        run_hdr(16'h4242, 16'h1, 64'h0, 1'b0, 1'b0, "R6");
        run_hdr(16'h4242, 16'h1, 64'h0, 1'b1, 1'b0, "R7");
        // R10: a catch-all write during a search is dropped.
        run_hdr(16'h4242, 16'h2, 64'h0, 1'b1, 1'b1, "R10");
        run_hdr(16'h4242, 16'h2, 64'h0, 1'b0, 1'b0, "R10");
        // R10: a write while idle takes effect at once.
        put_entry(0, 1, 16'h4242, 0, 16'h2, 0, 64'h0, 64'h0, 8'h01);
        run_hdr(16'h4242, 16'h2, 64'h0, 1'b0, 1'b0, "R10");

        // Random phase: small value ranges so entries overlap and collide.
        for (int i = 0; i < N; i++)
            put_entry(i, ($urandom % 4) != 0, 16'($urandom % 4), ($urandom % 6) == 0,
                      16'($urandom % 4), ($urandom % 6) == 0, {$urandom, $urandom},
                      ($urandom % 2) ? {32'd0, $urandom} : 64'd0, 8'($urandom));
        for (int it = 0; it < 200; it++) begin
            if (($urandom % 8) == 0)
                put_entry(int'($urandom % N), ($urandom % 4) != 0, 16'($urandom % 4),
                          ($urandom % 6) == 0, 16'($urandom % 4), ($urandom % 6) == 0,
                          {$urandom, $urandom}, ($urandom % 2) ? {32'd0, $urandom} : 64'd0,
                          8'($urandom));
            begin
                int src;
                src = int'($urandom % N);
                g = 16'($urandom % 4);
                r = 16'($urandom % 4);
                k = m_key[src] ^ (m_kign[src] & {$urandom, $urandom});
                if (($urandom % 4) == 0) k = {$urandom, $urandom};
                run_hdr(g, r, k, 1'($urandom), ($urandom % 10) == 0, "R2");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule